// File: doc/BRIEF.md
# Segmented Exponential Lookup Approximator

This block approximates e^x for a signed fixed-point input. A single table stores samples of the function. The table is not spaced evenly. The input span is cut into regions, and each region has its own sampling pitch. Regions where the exponential rises steeply are sampled finely. Regions where it is nearly flat are sampled coarsely. Each region is one contiguous slice of the table, so the total sample count stays small while the error is held down where the curve is steep.

Each cycle the block does the following:
- It compares the input against the region lower limits.
- It forms a table address from the offset into the selected region, shifted by that region's power-of-two pitch, plus the region's start position in the table.
- It reads the sample at that address and registers it as the output.

The output is the sample at the nearest lower grid point of the selected region. No interpolation is done. Inputs outside the covered span clamp to the first or last sample. The table contents are computed at elaboration from the region configuration. A datapath uses it as a per-cycle function evaluator, for example to supply the exponential terms of a neuron or synapse model.

Top module: `seg_exp_lut`

## Requirements
- R1: The output is registered. A new input appears at the output after exactly one rising clock edge. The output does not change between edges. An active-low asynchronous reset forces the output to zero.
- R2: The input is signed 8-bit two's complement with 4 fractional bits (raw value / 16). The region is chosen by lower limits in raw units: region 0 covers -64..-1, region 1 covers 0..31, region 2 covers 32..47, and region 3 covers 48..63. A raw value equal to a limit belongs to the region that starts there.
- R3: The region pitches in raw LSBs are 8, 4, 2 and 1 for regions 0 to 3. The sample point is xs = lo + floor((x - lo) / pitch) * pitch, where lo is the region's lower limit.
- R4: The output is unsigned 16-bit with 8 fractional bits. It equals round(e^(xs/16) * 256) to within 1 LSB. It never decreases when the input does not decrease.
- R5: Raw inputs below -64 give the same output as raw -64, that is e^-4.
- R6: Raw inputs above 63 give the same output as raw 63, that is e^(63/16).
- R7: For inputs inside the covered span, the output differs from the exact e^(x/16) by no more than e^((xs+pitch)/16) - e^(xs/16) + 2/256.
- R8: A new input can be accepted every cycle. If the input is held, the output holds.
- R9: All regions share one table of 40 entries. Regions occupy consecutive slices starting at entries 0, 8, 16 and 24. The read address never leaves that range.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the output register updates on its rising edge |
| rstN | input | 1 | Asynchronous active-low reset; clears the output |
| inX | input | 8 | Signed input, 4 fractional bits |
| lutOut | output | 16 | Registered approximation of e^x, 8 fractional bits |

## Verification
The assertions check, on every cycle, the structural rules of the block:
- exactly one choice among the two clamp cases and the four regions is active;
- the clamp cases force the first or last table address;
- the address stays inside the table;
- the output is monotone over successive inputs, and it holds while the input holds.

The numerical behaviour is shown only by the bench scenarios. These cover the sample point chosen at each limit and pitch, the rounded sample values, the per-region error bound against a real-valued exponential, and the reset and latency timing.

// File: rtl/seg_lut_pkg.sv
package seg_lut_pkg;

  // Region configuration, raw input units (LSB = 2^-INFRAC)
  localparam int NREG = 4;
  localparam int REG_LO    [NREG] = '{-64, 0, 32, 48};
  localparam int REG_SHIFT [NREG] = '{3, 2, 1, 0};
  localparam int RANGE_END = 64;   // first raw value above the covered span

  function automatic int regionEnd(int r);
    int e;
    e = RANGE_END;
    for (int i = 0; i < NREG - 1; i++)
      if (i == r) e = REG_LO[i + 1];
    return e;
  endfunction

  function automatic int regionSize(int r);
    return (regionEnd(r) - REG_LO[r]) >>> REG_SHIFT[r];
  endfunction

  function automatic int regionBase(int r);
    int acc;
    acc = 0;
    for (int i = 0; i < NREG; i++)
      if (i < r) acc += regionSize(i);
    return acc;
  endfunction

  localparam int ROM_DEPTH = regionBase(NREG);

  // Strobes from region control to the datapath
  typedef struct packed {
    logic            satLow;
    logic            satHigh;
    logic [NREG-1:0] regionHit;
  } lutCtrl_t;

endpackage

// File: rtl/lut_region_ctrl.sv
module lut_region_ctrl
  import seg_lut_pkg::*;
#(
  parameter int INW = 8
) (
  input  logic signed [INW-1:0] inX,
  output lutCtrl_t              ctrlS
);

  logic [NREG-1:0] geLo;
  logic            aboveTop;

  assign aboveTop = (int'(inX) >= RANGE_END);

  // Comparator chain against each region's lower limit
  for (genvar r = 0; r < NREG; r++) begin : gCmp
    assign geLo[r] = (int'(inX) >= REG_LO[r]);
  end

  // A region wins when its limit is met and the next one is not
  for (genvar r = 0; r < NREG; r++) begin : gHit
    if (r < NREG - 1) begin : gMid
      assign ctrlS.regionHit[r] = geLo[r] & ~geLo[r + 1];
    end else begin : gLast
      assign ctrlS.regionHit[r] = geLo[r] & ~aboveTop;
    end
  end

  assign ctrlS.satLow  = ~geLo[0];
  assign ctrlS.satHigh = aboveTop;

endmodule

// File: rtl/lut_rom_path.sv
module lut_rom_path
  import seg_lut_pkg::*;
#(
  parameter int INW     = 8,
  parameter int INFRAC  = 4,
  parameter int OUTW    = 16,
  parameter int OUTFRAC = 8,
  parameter int AW      = 6
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic signed [INW-1:0] inX,
  input  lutCtrl_t              ctrlS,
  output logic [AW-1:0]         romAddr,
  output logic [OUTW-1:0]       lutOut
);

  localparam int QF = 28;   // internal fraction bits for table generation

  // Raw input value of table entry g
  function automatic int sampleRaw(int g);
    int raw;
    raw = 0;
    for (int r = 0; r < NREG; r++)
      if (g >= regionBase(r))
        raw = REG_LO[r] + ((g - regionBase(r)) <<< REG_SHIFT[r]);
    return raw;
  endfunction

  // round(e^(raw / 2^INFRAC) * 2^OUTFRAC), integer arithmetic only
  function automatic longint expFix(int raw);
    longint term, stepE, acc, res, maxV;
    int     k;
    term  = longint'(1) <<< QF;
    stepE = term;
    for (int n = 1; n <= 10; n++) begin
      term  = (term >>> INFRAC) / n;
      stepE = stepE + term;
    end
    acc = longint'(1) <<< QF;
    k   = (raw < 0) ? -raw : raw;
    for (int i = 0; i < k; i++)
      acc = (acc * stepE + (longint'(1) <<< (QF - 1))) >>> QF;
    if (raw < 0)
      acc = ((longint'(1) <<< (2 * QF)) + acc / 2) / acc;
    res  = (acc + (longint'(1) <<< (QF - OUTFRAC - 1))) >>> (QF - OUTFRAC);
    maxV = (longint'(1) <<< OUTW) - 1;
    if (res > maxV) res = maxV;
    return res;
  endfunction

  // Shared sample store, filled at elaboration
  logic [OUTW-1:0] romArr [ROM_DEPTH];
  for (genvar g = 0; g < ROM_DEPTH; g++) begin : gRom
    assign romArr[g] = OUTW'(expFix(sampleRaw(g)));
  end

  // Per-region candidate addresses
  logic [AW-1:0] cand [NREG];
  for (genvar r = 0; r < NREG; r++) begin : gAddr
    assign cand[r] = AW'(regionBase(r) + ((int'(inX) - REG_LO[r]) >>> REG_SHIFT[r]));
  end

  logic [AW-1:0] addrMux;
  always_comb begin
    addrMux = '0;
    for (int r = 0; r < NREG; r++)
      if (ctrlS.regionHit[r]) addrMux = addrMux | cand[r];
    if (ctrlS.satLow)       romAddr = '0;
    else if (ctrlS.satHigh) romAddr = AW'(ROM_DEPTH - 1);
    else                    romAddr = addrMux;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lutOut <= '0;
    else       lutOut <= romArr[romAddr];
  end

endmodule

// File: rtl/seg_exp_lut.sv
module seg_exp_lut
  import seg_lut_pkg::*;
#(
  parameter int INW     = 8,
  parameter int INFRAC  = 4,
  parameter int OUTW    = 16,
  parameter int OUTFRAC = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic signed [INW-1:0] inX,
  output logic [OUTW-1:0]       lutOut
);

  localparam int ADDR_W = $clog2(ROM_DEPTH);

  lutCtrl_t          ctrlS;
  logic [ADDR_W-1:0] romAddr;

  lut_region_ctrl #(.INW(INW)) u_ctrl (
    .inX   (inX),
    .ctrlS (ctrlS)
  );

  lut_rom_path #(
    .INW(INW), .INFRAC(INFRAC), .OUTW(OUTW), .OUTFRAC(OUTFRAC), .AW(ADDR_W)
  ) u_path (
    .clk     (clk),
    .rstN    (rstN),
    .inX     (inX),
    .ctrlS   (ctrlS),
    .romAddr (romAddr),
    .lutOut  (lutOut)
  );

endmodule

// File: rtl/seg_exp_lut_chk.sv
module seg_exp_lut_chk
  import seg_lut_pkg::*;
#(
  parameter int INW  = 8,
  parameter int OUTW = 16,
  parameter int AW   = 6
) (
  input logic                  clk,
  input logic                  rstN,
  input logic signed [INW-1:0] inX,
  input logic [OUTW-1:0]       lutOut,
  input logic                  satLow,
  input logic                  satHigh,
  input logic [NREG-1:0]       regionHit,
  input logic [AW-1:0]         romAddr
);

  // R2: exactly one of clamp-low, clamp-high or a region is chosen
  a_r2_one_select: assert property (@(posedge clk) disable iff (!rstN)
    $onehot({satLow, satHigh, regionHit}));

  // R5: low clamp reads the first entry
  a_r5_low_clamp_addr: assert property (@(posedge clk) disable iff (!rstN)
    satLow |-> (romAddr == '0));

  // R6: high clamp reads the last entry
  a_r6_high_clamp_addr: assert property (@(posedge clk) disable iff (!rstN)
    satHigh |-> (int'(romAddr) == ROM_DEPTH - 1));

  // R9: address stays inside the shared table
  a_r9_addr_range: assert property (@(posedge clk) disable iff (!rstN)
    int'(romAddr) < ROM_DEPTH);

  // R8: a held input gives a held output
  a_r8_hold: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $stable(inX)) |=> $stable(lutOut));

  // R4: output never falls when the input does not fall
  a_r4_monotone: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && (inX >= $past(inX))) |=> (lutOut >= $past(lutOut)));

endmodule

bind seg_exp_lut seg_exp_lut_chk #(.INW(INW), .OUTW(OUTW), .AW(ADDR_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .inX       (inX),
  .lutOut    (lutOut),
  .satLow    (ctrlS.satLow),
  .satHigh   (ctrlS.satHigh),
  .regionHit (ctrlS.regionHit),
  .romAddr   (romAddr)
);

// File: tb/seg_exp_lut_tb.sv
`timescale 1ns/1ps
module seg_exp_lut_tb;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic signed [7:0] inX = '0;
  logic [15:0]       lutOut;

  int nChecks = 0;
  int nFails  = 0;

  always #2.5 clk = ~clk;

  seg_exp_lut u_dut (.clk(clk), .rstN(rstN), .inX(inX), .lutOut(lutOut));

  localparam int LO [4]   = '{-64, 0, 32, 48};
  localparam int STEP [4] = '{8, 4, 2, 1};

  function automatic int regOf(int x);
    int r;
    r = 0;
    for (int i = 0; i < 4; i++) if (x >= LO[i]) r = i;
    return r;
  endfunction

  function automatic int samplePt(int x);
    int c, r;
    c = (x < -64) ? -64 : ((x > 63) ? 63 : x);
    r = regOf(c);
    return LO[r] + ((c - LO[r]) / STEP[r]) * STEP[r];
  endfunction

  function automatic int refCode(int xs);
    return $rtoi($exp(real'(xs) / 16.0) * 256.0 + 0.5);
  endfunction

  task automatic report(bit ok, string req, int act, int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic checkCode(int x, string req);
    int e, d;
    e = refCode(samplePt(x));
    d = int'(lutOut) - e;
    report((d >= -1) && (d <= 1), req, int'(lutOut), e);
  endtask

  // drive at a falling edge, sample at the next falling edge
  task automatic applyX(int x);
    @(negedge clk);
    inX = 8'(x);
    @(negedge clk);
  endtask

  task automatic t_reset();  // R1
    inX = 8'sd40;
    repeat (3) @(negedge clk);
    report(lutOut == 16'd0, "R1 reset clears", int'(lutOut), 0);
    rstN = 1'b1;
    @(negedge clk);
    checkCode(40, "R1 first value after reset");
  endtask

  task automatic t_latency();  // R1
    int old;
    applyX(-20);
    old = int'(lutOut);
    @(negedge clk);
    inX = 8'sd60;
    #1;
    report(int'(lutOut) == old, "R1 no change before edge", int'(lutOut), old);
    @(negedge clk);
    checkCode(60, "R1 one edge latency");
    rstN = 1'b0;
    #1;
    report(lutOut == 16'd0, "R1 asynchronous clear", int'(lutOut), 0);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_sweep();  // R2 R3 R4 R7
    for (int x = -64; x <= 63; x++) begin
      real trueV, gotV, err, bound;
      int  xs;
      applyX(x);
      checkCode(x, "R4 sample value");
      xs    = samplePt(x);
      trueV = $exp(real'(x) / 16.0);
      gotV  = real'(lutOut) / 256.0;
      err   = (gotV > trueV) ? gotV - trueV : trueV - gotV;
      bound = $exp(real'(xs + STEP[regOf(x)]) / 16.0) - $exp(real'(xs) / 16.0) + 2.0 / 256.0;
      report(err <= bound, "R7 error bound", $rtoi(err * 65536.0), $rtoi(bound * 65536.0));
    end
  endtask

  task automatic t_limits();  // R2 R3
    int prevV;
    // last point of each region versus first point of the next
    applyX(-1);  prevV = int'(lutOut);
    report(int'(lutOut) == refCode(-8) || int'(lutOut) - refCode(-8) == 1 || refCode(-8) - int'(lutOut) == 1,
           "R2 raw -1 in region 0 pitch 8", int'(lutOut), refCode(-8));
    applyX(0);
    report(int'(lutOut) > prevV, "R2 raw 0 opens region 1", int'(lutOut), prevV + 1);
    applyX(31); checkCode(31, "R3 raw 31 pitch 4 gives sample 28");
    applyX(33); checkCode(33, "R3 raw 33 pitch 2 gives sample 32");
    applyX(47); checkCode(47, "R3 raw 47 gives sample 46");
    applyX(49); prevV = int'(lutOut);
    applyX(48);
    report(int'(lutOut) < prevV, "R3 pitch 1 in region 3", int'(lutOut), prevV - 1);
  endtask

  task automatic t_clamp();  // R5 R6 R9
    applyX(-64);
    report(int'(lutOut) == refCode(-64) || int'(lutOut) == refCode(-64) + 1 || int'(lutOut) == refCode(-64) - 1,
           "R9 first entry", int'(lutOut), refCode(-64));
    applyX(-128); checkCode(-64, "R5 clamp -128");
    applyX(-65);  checkCode(-64, "R5 clamp -65");
    applyX(63);   checkCode(63,  "R9 last entry");
    applyX(64);   checkCode(63,  "R6 clamp 64");
    applyX(127);  checkCode(63,  "R6 clamp 127");
  endtask

  task automatic t_stream();  // R8
    int seq [8] = '{5, -100, 62, 17, -3, 100, 40, 50};
    @(negedge clk);
    inX = 8'(seq[0]);
    for (int i = 1; i < 8; i++) begin
      @(negedge clk);
      checkCode(seq[i - 1], "R8 back-to-back");
      inX = 8'(seq[i]);
    end
    @(negedge clk);
    checkCode(seq[7], "R8 back-to-back last");
    @(negedge clk);
    checkCode(seq[7], "R8 held input holds output");
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
  endtask

  initial begin
    #(5.0 * 150000);
    nChecks++;
    nFails++;
    $display("FAIL R8 watchdog: actual hung expected finish");
    summary();
    $finish;
  end

  initial begin
    t_reset();
    t_latency();
    t_sweep();
    t_limits();
    t_clamp();
    t_stream();
    summary();
    $finish;
  end

endmodule